// File: doc/BRIEF.md
# Multiplexed-Bus SRAM Glue with Low-Address Hold

This block sits between a microcontroller whose low address byte and data byte share eight pins, and an 8 KB asynchronous static RAM. During the first part of each bus cycle the shared pins carry the low address and an address strobe is high. The block keeps that byte for the rest of the cycle, so the RAM sees a stable 13-bit address. It also decodes the top three address bits into one of eight 8 KB windows and selects the RAM only when window 2 (addresses 0x4000 to 0x5FFF) is hit while the bus phase signal is high.

The shared pins appear as a split pair: `mux_in_i` is what the bus carries and `mux_out_o` with `mux_drive_o` is what the block would put on it. A small phase tracker follows each cycle through four states. PH_IDLE moves to PH_ADDR when the strobe rises. PH_ADDR moves to PH_HOLD when the strobe falls. PH_HOLD moves to PH_DATA when the phase signal rises, or back to PH_ADDR if the strobe rises again. PH_DATA returns to PH_IDLE when the phase signal falls. Read data is returned only in a data phase that an address phase came before. The block runs on the oscillator clock `clk`, and every bus input is synchronous to it.

Top module: `muxbus_sram_glue`

## Requirements
- R1: While `addr_strobe_i` is 1, `mem_addr_o[7:0]` equals `mux_in_i` in the same cycle.
- R2: While `addr_strobe_i` is 0, `mem_addr_o[7:0]` holds the value `mux_in_i` had in the last clock cycle in which the strobe was 1, whatever the bus then carries.
- R3: `mem_addr_o[12:8]` equals `addr_hi_i[4:0]` at all times.
- R4: `mem_sel_n_o` is 0 exactly when `bus_phase_i` is 1 and `addr_hi_i[7:5]` equals 3'b010. Bits `addr_hi_i[4:0]` play no part in the selection (partial decoding).
- R5: `mem_wr_n_o` is 0 exactly when `bus_phase_i` is 1 and `read_not_write_i` is 0 (1 means read, 0 means write).
- R6: `mem_sel_o`, the active-high select, is always 1.
- R7: `mem_rd_n_o` is 0 exactly when `mem_sel_n_o` is 0 and `read_not_write_i` is 1, so it is never low together with `mem_wr_n_o`.
- R8: `mux_drive_o` is 1 exactly when `mem_rd_n_o` is 0 and the phase tracker is in PH_HOLD or PH_DATA. If it is not, the read is not returned. While it is 1, `mux_out_o` equals `mem_rdata_i`; otherwise it is 0.
- R9: `mem_wdata_o` equals `mux_in_i` at all times, so a write in the window stores the byte the bus carries while the phase signal is high.
- R10: A write outside window 2 leaves the RAM unchanged. A read outside window 2 never drives the bus.
- R11: During reset the held low address is 0, the tracker is in PH_IDLE, and with all bus inputs low every strobe output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; bus inputs change synchronously to it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_phase_i | input | 1 | Bus phase; high in the data half of a cycle |
| addr_strobe_i | input | 1 | Address strobe; high while the shared pins carry the low address |
| read_not_write_i | input | 1 | 1 = read, 0 = write |
| addr_hi_i | input | 8 | Upper address byte |
| mux_in_i | input | 8 | Value present on the shared address/data pins |
| mux_out_o | output | 8 | Read data to place on the shared pins |
| mux_drive_o | output | 1 | 1 when the block drives the shared pins |
| mem_addr_o | output | 13 | RAM address |
| mem_sel_n_o | output | 1 | Active-low RAM select |
| mem_sel_o | output | 1 | Active-high RAM select, tied asserted |
| mem_wr_n_o | output | 1 | Active-low RAM write enable |
| mem_rd_n_o | output | 1 | Active-low RAM output enable |
| mem_wdata_o | output | 8 | Data to the RAM |
| mem_rdata_i | input | 8 | Data from the RAM |

## Verification
On every cycle the assertions check that the held low byte matches the byte seen before the strobe fell and stays still while the strobe is low. They also check that at most one window decodes, that read and write enables never overlap, that the bus is driven only during a RAM read, and that PH_DATA is entered only from an address-bearing state. Only the bench's scenarios can show that data written through window 2 comes back at the right 13-bit address. The same goes for a write in any other window leaving the RAM unchanged, for aliasing under partial decoding, and for a phase pulse with no preceding strobe not being answered. The bench sweeps all eight windows, all 256 low-address values and a spread of middle address bits against a scoreboard of its own.

// File: rtl/glue_pkg.sv
package glue_pkg;

    // Bus-cycle phase seen by the tracker
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_HOLD = 2'd2,
        PH_DATA = 2'd3
    } bus_phase_e;

endpackage

// File: rtl/lo_addr_hold.sv
module lo_addr_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] held_q;

    // Captures every cycle the strobe is open; the last capture survives its fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (open_i) begin
            held_q <= d_i;
        end
    end

    // Open: pass straight through. Closed: present the held byte.
    always_comb begin
        if (open_i) begin
            q_o = d_i;
        end else begin
            q_o = held_q;
        end
    end

    // R1 / R2: byte after the strobe falls is the one seen just before it fell
    a_r1_capture_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_i) |-> (q_o == $past(d_i)));

    // R2: closed strobe keeps the output still
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_i && $past(!open_i)) |-> $stable(q_o));

endmodule

// File: rtl/window_decoder.sv
module window_decoder #(
    parameter int SEL_W = 3
) (
    input  logic               en_i,
    input  logic [SEL_W-1:0]   field_i,
    output logic [(1<<SEL_W)-1:0] sel_o
);

    localparam int BLOCKS = 1 << SEL_W;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        assign sel_o[b] = en_i && (field_i == SEL_W'(b));
    end

    // R4: never two windows at once
    always_comb begin
        a_r4_onehot: assert ($onehot0(sel_o));
    end

endmodule

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
    import glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic phase_i,
    output logic data_ok_o
);

    bus_phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (strobe_i) state_d = PH_ADDR;
            PH_ADDR: if (!strobe_i) state_d = PH_HOLD;
            PH_HOLD: begin
                if (strobe_i) begin
                    state_d = PH_ADDR;
                end else if (phase_i) begin
                    state_d = PH_DATA;
                end
            end
            PH_DATA: if (!phase_i) state_d = PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    // Outputs: a data phase counts only after an address phase
    always_comb begin
        data_ok_o = 1'b0;
        unique case (state_q)
            PH_HOLD, PH_DATA: data_ok_o = phase_i;
            default:          data_ok_o = 1'b0;
        endcase
    end

    // R8: PH_DATA is reached only through a held address
    a_r8_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DATA) |-> ($past(state_q) == PH_HOLD || $past(state_q) == PH_DATA));

endmodule

// File: rtl/muxbus_sram_glue.sv
module muxbus_sram_glue
    import glue_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 13,
    parameter int WINDOW = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_phase_i,
    input  logic                     addr_strobe_i,
    input  logic                     read_not_write_i,
    input  logic [ADDR_W-DATA_W-1:0] addr_hi_i,
    input  logic [DATA_W-1:0]        mux_in_i,
    output logic [DATA_W-1:0]        mux_out_o,
    output logic                     mux_drive_o,
    output logic [MEM_AW-1:0]        mem_addr_o,
    output logic                     mem_sel_n_o,
    output logic                     mem_sel_o,
    output logic                     mem_wr_n_o,
    output logic                     mem_rd_n_o,
    output logic [DATA_W-1:0]        mem_wdata_o,
    input  logic [DATA_W-1:0]        mem_rdata_i
);

    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int SEL_W  = ADDR_W - MEM_AW;
    localparam int MID_W  = MEM_AW - DATA_W;
    localparam int BLOCKS = 1 << SEL_W;

    logic [DATA_W-1:0] lo_addr;
    logic [BLOCKS-1:0] blk_sel;
    logic              data_ok;
    logic              hit;

    lo_addr_hold #(.W(DATA_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (addr_strobe_i),
        .d_i    (mux_in_i),
        .q_o    (lo_addr)
    );

    window_decoder #(.SEL_W(SEL_W)) u_dec (
        .en_i    (bus_phase_i),
        .field_i (addr_hi_i[HI_W-1 -: SEL_W]),
        .sel_o   (blk_sel)
    );

    bus_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (addr_strobe_i),
        .phase_i   (bus_phase_i),
        .data_ok_o (data_ok)
    );

    assign hit         = blk_sel[WINDOW];
    assign mem_addr_o  = {addr_hi_i[MID_W-1:0], lo_addr};
    assign mem_sel_n_o = ~hit;
    assign mem_sel_o   = 1'b1;
    assign mem_wr_n_o  = ~(bus_phase_i & ~read_not_write_i);
    assign mem_rd_n_o  = ~(hit & read_not_write_i);
    assign mem_wdata_o = mux_in_i;
    assign mux_drive_o = ~mem_rd_n_o & data_ok;
    assign mux_out_o   = mux_drive_o ? mem_rdata_i : '0;

    // R7: output and write enables never overlap
    a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n_o && !mem_wr_n_o));

    // R8: bus driven only while the RAM output is enabled
    a_r8_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mux_drive_o |-> (!mem_rd_n_o && !mem_sel_n_o));

    // R4: select only in the high bus phase
    a_r4_sel_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n_o |-> bus_phase_i);

    // R10: a write enable with no select cannot reach the RAM data path as a read
    a_r10_no_drive_outside: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n_o |-> !mux_drive_o);

endmodule

// File: tb/muxbus_sram_glue_tb_top.sv
module sram_model_tb (
    input  logic        clk,
    input  logic [12:0] addr,
    input  logic        sel_n,
    input  logic        sel,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic [7:0]  wd,
    output logic [7:0]  rd
);
    logic [7:0] mem [int unsigned];

    initial rd = 8'h00;

    always @(negedge clk) begin
        if (!sel_n && sel && !wr_n) mem[int'(addr)] = wd;
    end

    always @(posedge clk) begin
        if (!sel_n && sel && !rd_n && mem.exists(int'(addr))) rd <= mem[int'(addr)];
        else rd <= 8'h00;
    end
endmodule

module muxbus_sram_glue_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase = 1'b0;
    logic        strobe = 1'b0;
    logic        rnw = 1'b0;
    logic [7:0]  hi = 8'h00;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        drive;
    logic [12:0] maddr;
    logic        sel_n, sel, wr_n, rd_n;
    logic [7:0]  wdata, rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_mem [int unsigned];

    always #5 clk = ~clk;

    muxbus_sram_glue dut_i (
        .clk(clk), .rst_n(rst_n), .bus_phase_i(phase), .addr_strobe_i(strobe),
        .read_not_write_i(rnw), .addr_hi_i(hi), .mux_in_i(bus_in),
        .mux_out_o(bus_out), .mux_drive_o(drive), .mem_addr_o(maddr),
        .mem_sel_n_o(sel_n), .mem_sel_o(sel), .mem_wr_n_o(wr_n), .mem_rd_n_o(rd_n),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata)
    );

    sram_model_tb u_ram (
        .clk(clk), .addr(maddr), .sel_n(sel_n), .sel(sel), .wr_n(wr_n),
        .rd_n(rd_n), .wd(wdata), .rd(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // One bus cycle; checks are taken at the falling clock edge
    task automatic bus_cycle(input logic [15:0] a, input logic is_rd, input logic [7:0] wd);
        logic in_win;
        logic [31:0] key;
        logic [7:0] exp_rd;
        in_win = (a[15:13] == 3'b010);
        key = {19'd0, a[12:0]};
        exp_rd = exp_mem.exists(key) ? exp_mem[key] : 8'h00;
        // address phase
        step(); strobe = 1'b1; hi = a[15:8]; bus_in = a[7:0]; rnw = 1'b1;
        @(negedge clk);
        check("R1 low byte passes", 32'(maddr[7:0]), 32'(a[7:0]));
        check("R3 middle bits", 32'(maddr[12:8]), 32'(a[12:8]));
        check("R4 no select in low phase", 32'(sel_n), 32'd1);
        // strobe falls, pins turn around
        step(); strobe = 1'b0; bus_in = ~a[7:0];
        @(negedge clk);
        check("R2 low byte held", 32'(maddr[7:0]), 32'(a[7:0]));
        // data phase
        step(); phase = 1'b1; rnw = is_rd; bus_in = is_rd ? 8'hA5 : wd;
        @(negedge clk);
        check("R4 select", 32'(sel_n), 32'(!in_win));
        check("R5 write enable", 32'(wr_n), 32'(is_rd));
        check("R7 output enable", 32'(rd_n), 32'(!(in_win && is_rd)));
        check("R8 drive", 32'(drive), 32'(in_win && is_rd));
        check("R9 write data", 32'(wdata), 32'(bus_in));
        check("R6 high select", 32'(sel), 32'd1);
        check("R2 held in data phase", 32'(maddr), 32'(a[12:0]));
        step();
        @(negedge clk);
        if (in_win && is_rd) check("R8 read data", 32'(bus_out), 32'(exp_rd));
        else check("R10 undriven", 32'({drive, bus_out}), 32'd0);
        if (in_win && !is_rd) exp_mem[key] = wd;
        step(); phase = 1'b0; rnw = 1'b1;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset sel_n", 32'(sel_n), 32'd1);
        check("R11 reset wr_n", 32'(wr_n), 32'd1);
        check("R11 reset rd_n", 32'(rd_n), 32'd1);
        check("R11 reset drive", 32'(drive), 32'd0);
        check("R11 reset low addr", 32'(maddr[7:0]), 32'd0);
        step(); rst_n = 1'b1;
        step();

        // Writes across all eight windows (R4, R5, R9, R10)
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < 6; k++) begin
                logic [15:0] a;
                a = {3'(b), 5'((k * 7 + b) % 32), 8'(k * 37 + b * 11)};
                bus_cycle(a, 1'b0, a[7:0] ^ a[15:8] ^ 8'h5A);
            end
        end
        // Read back at each address and at its window-2 alias (R8, R10)
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < 6; k++) begin
                logic [15:0] a;
                a = {3'(b), 5'((k * 7 + b) % 32), 8'(k * 37 + b * 11)};
                bus_cycle(a, 1'b1, 8'h00);
                bus_cycle({3'b010, a[12:0]}, 1'b1, 8'h00);
            end
        end
        // Full low-byte sweep: write then read in window 2 (R1, R2, R3)
        for (int l = 0; l < 256; l++) begin
            bus_cycle({3'b010, 5'd19, 8'(l)}, 1'b0, 8'(l * 3 + 1));
        end
        for (int l = 0; l < 256; l++) begin
            bus_cycle({3'b010, 5'd19, 8'(l)}, 1'b1, 8'h00);
        end

        // Phase pulse with no preceding strobe: select yes, drive no (R8)
        step(); hi = 8'h40; rnw = 1'b1; phase = 1'b1;
        @(negedge clk);
        check("R4 select without strobe", 32'(sel_n), 32'd0);
        check("R8 no drive without address phase", 32'(drive), 32'd0);
        step(); phase = 1'b0;
        step();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule